// File: doc/BRIEF.md
# Prescaled Timebase with Event Snapshot

This block is a timebase made of two counters in series. A prescale counter advances by one on every clock. When it equals a programmable terminal value, it returns to zero and the 32-bit main counter advances by one. The terminal value therefore sets how many clocks make up one main-counter tick. A single run bit starts and stops both counters. While the counters are stopped, software may preload either one.

A selector picks one of six event inputs. A rising edge on the chosen input copies the prescale count and the main count, as they stand in that cycle, into two snapshot registers. Both live counts and both snapshots are outputs of the block.

Top module: `tick_timebase`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `pre_q`, `frc_q`, `cap_pre_q` and `cap_frc_q` are all zero.
- R2: While `run` is high and `pre_q` differs from `cmp_val`, `pre_q` rises by one at each clock edge.
- R3: While `run` is high and `pre_q` equals `cmp_val`, the next edge sets `pre_q` to zero and raises `frc_q` by one.
- R4: With `cmp_val` at zero and `run` high, `pre_q` stays at zero and `frc_q` advances on every clock.
- R5: While `run` is low and no load is requested, `pre_q` and `frc_q` keep their values.
- R6: While `run` is low, `ld_pre` loads `wr_data[PRE_W-1:0]` into `pre_q` and `ld_frc` loads `wr_data` into `frc_q` at the next edge.
- R7: While `run` is high, `ld_pre` and `ld_frc` have no effect.
- R8: `frc_q` advances from 0xFFFFFFFF to 0x00000000.
- R9: Codes 0 to 5 on `src_sel` select `evt_in[src_sel]`. When that input is sampled high after it was sampled low on the previous edge, the next edge loads `cap_pre_q` and `cap_frc_q` with the `pre_q` and `frc_q` values seen before that edge. This works whether `run` is high or low.
- R10: An input held high gives only one snapshot. Edges on inputs that are not selected give none, and codes 6 and 7 on `src_sel` select no input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Counting enable |
| cmp_val | input | PRE_W | Prescale terminal value |
| ld_pre | input | 1 | Load prescale counter (only while stopped) |
| ld_frc | input | 1 | Load main counter (only while stopped) |
| wr_data | input | FRC_W | Load data |
| src_sel | input | SEL_W | Event source select |
| evt_in | input | N_SRC | Event inputs |
| pre_q | output | PRE_W | Live prescale count |
| frc_q | output | FRC_W | Live main count |
| cap_pre_q | output | PRE_W | Snapshot of prescale count |
| cap_frc_q | output | FRC_W | Snapshot of main count |

## Verification
All results appear one clock after the inputs that cause them. This covers counting, wrapping, loads and snapshots. The snapshot holds the counts from the cycle in which the edge was sampled, not the updated counts. The bench drives inputs on the falling edge and advances its behavioural model on the rising edge from those same inputs. It compares every output with the model on the next falling edge, so each result is checked in the cycle it is due. Directed checks with hand-computed values cover the loads, the wrap, an ignored load while running, and one snapshot per held event.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  localparam int unsigned DEF_PRE_W = 16;
  localparam int unsigned DEF_FRC_W = 32;
  localparam int unsigned DEF_N_SRC = 6;
endpackage

// File: rtl/tb_prescaler.sv
module tb_prescaler #(
  parameter int unsigned PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PRE_W-1:0] cmp_val,
  input  logic             ld,
  input  logic [PRE_W-1:0] ld_val,
  output logic [PRE_W-1:0] cnt_q,
  output logic             tick
);
  assign tick = run && (cnt_q == cmp_val);

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (!run) begin
      if (ld)              cnt_q <= ld_val;
    end
    else if (tick)         cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (run && cnt_q != cmp_val) |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    (run && cnt_q == cmp_val) |=> cnt_q == '0);
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!run && !ld) |=> $stable(cnt_q));
endmodule

// File: rtl/tb_main_counter.sv
module tb_main_counter #(
  parameter int unsigned FRC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             ld,
  input  logic [FRC_W-1:0] ld_val,
  output logic [FRC_W-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (!run) begin
      if (ld)              cnt_q <= ld_val;
    end
    else if (tick)         cnt_q <= cnt_q + 1'b1;
  end

  a_r3_advance: assert property (@(posedge clk) disable iff (rst)
    tick |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r7_no_load_running: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/tb_snapshot.sv
module tb_snapshot #(
  parameter int unsigned PRE_W = 16,
  parameter int unsigned FRC_W = 32,
  parameter int unsigned N_SRC = 6,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] src_sel,
  input  logic [N_SRC-1:0] evt_in,
  input  logic [PRE_W-1:0] pre_in,
  input  logic [FRC_W-1:0] frc_in,
  output logic [PRE_W-1:0] cap_pre_q,
  output logic [FRC_W-1:0] cap_frc_q
);
  logic [N_SRC-1:0] evt_d;
  logic [N_SRC-1:0] rise;
  logic             fire;

  for (genvar i = 0; i < N_SRC; i++) begin : g_edge
    assign rise[i] = evt_in[i] & ~evt_d[i];
  end

  always_comb begin
    fire = 1'b0;
    for (int k = 0; k < N_SRC; k++)
      if (int'(src_sel) == k) fire = rise[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_d     <= '0;
      cap_pre_q <= '0;
      cap_frc_q <= '0;
    end else begin
      evt_d <= evt_in;
      if (fire) begin
        cap_pre_q <= pre_in;
        cap_frc_q <= frc_in;
      end
    end
  end

  a_r9_snap: assert property (@(posedge clk) disable iff (rst)
    fire |=> (cap_pre_q == $past(pre_in)) && (cap_frc_q == $past(frc_in)));
  a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(cap_pre_q) && $stable(cap_frc_q));
  a_r10_bad_sel: assert property (@(posedge clk) disable iff (rst)
    (int'(src_sel) >= N_SRC) |-> !fire);
endmodule

// File: rtl/tick_timebase.sv
module tick_timebase #(
  parameter int unsigned PRE_W = tbase_pkg::DEF_PRE_W,
  parameter int unsigned FRC_W = tbase_pkg::DEF_FRC_W,
  parameter int unsigned N_SRC = tbase_pkg::DEF_N_SRC,
  localparam int unsigned SEL_W = $clog2(N_SRC + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PRE_W-1:0] cmp_val,
  input  logic             ld_pre,
  input  logic             ld_frc,
  input  logic [FRC_W-1:0] wr_data,
  input  logic [SEL_W-1:0] src_sel,
  input  logic [N_SRC-1:0] evt_in,
  output logic [PRE_W-1:0] pre_q,
  output logic [FRC_W-1:0] frc_q,
  output logic [PRE_W-1:0] cap_pre_q,
  output logic [FRC_W-1:0] cap_frc_q
);
  logic tick;

  tb_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .run(run), .cmp_val(cmp_val),
    .ld(ld_pre), .ld_val(wr_data[PRE_W-1:0]), .cnt_q(pre_q), .tick(tick)
  );

  tb_main_counter #(.FRC_W(FRC_W)) u_frc (
    .clk(clk), .rst(rst), .run(run), .tick(tick),
    .ld(ld_frc), .ld_val(wr_data), .cnt_q(frc_q)
  );

  tb_snapshot #(.PRE_W(PRE_W), .FRC_W(FRC_W), .N_SRC(N_SRC), .SEL_W(SEL_W)) u_snap (
    .clk(clk), .rst(rst), .src_sel(src_sel), .evt_in(evt_in),
    .pre_in(pre_q), .frc_in(frc_q), .cap_pre_q(cap_pre_q), .cap_frc_q(cap_frc_q)
  );

  a_r1_reset: assert property (@(posedge clk)
    rst |=> (pre_q == '0) && (frc_q == '0) && (cap_pre_q == '0) && (cap_frc_q == '0));
endmodule

// File: tb/tick_timebase_tb.sv
module tick_timebase_tb;
  localparam int PRE_W = 16;
  localparam int FRC_W = 32;
  localparam int N_SRC = 6;
  localparam int SEL_W = 3;

  logic clk = 0, rst = 1, run = 0, ld_pre = 0, ld_frc = 0;
  logic [PRE_W-1:0] cmp_val = '0;
  logic [FRC_W-1:0] wr_data = '0;
  logic [SEL_W-1:0] src_sel = '0;
  logic [N_SRC-1:0] evt_in = '0;
  logic [PRE_W-1:0] pre_q, cap_pre_q;
  logic [FRC_W-1:0] frc_q, cap_frc_q;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  longint m_pre, m_frc, m_cpre, m_cfrc;
  bit [N_SRC-1:0] m_prev;

  always #5 clk = ~clk;

  tick_timebase u_dut (.*);

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // behavioural reference, advanced from the same inputs the DUT samples
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_pre = 0; m_frc = 0; m_cpre = 0; m_cfrc = 0; m_prev = '0;
    end else begin
      if (src_sel < N_SRC && evt_in[src_sel] && !m_prev[src_sel]) begin
        m_cpre = m_pre; m_cfrc = m_frc;
      end
      m_prev = evt_in;
      if (!run) begin
        if (ld_pre) m_pre = wr_data % (64'd1 << PRE_W);
        if (ld_frc) m_frc = wr_data;
      end else if (m_pre == cmp_val) begin
        m_pre = 0;
        m_frc = (m_frc + 1) % (64'd1 << FRC_W);
      end else begin
        m_pre = m_pre + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 pre_q", pre_q, m_pre);
      chk("R3 frc_q", frc_q, m_frc);
      chk("R9 cap_pre_q", cap_pre_q, m_cpre);
      chk("R9 cap_frc_q", cap_frc_q, m_cfrc);
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) if (cycles > 100000 && !done) begin
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  logic [FRC_W-1:0] snap_frc;
  logic [PRE_W-1:0] snap_pre;

  initial begin
    step(3);
    rst = 0;
    step(1);
    chk("R1 pre", pre_q, 0); chk("R1 frc", frc_q, 0);
    chk("R1 cap_pre", cap_pre_q, 0); chk("R1 cap_frc", cap_frc_q, 0);

    // R6 loads while stopped
    wr_data = 32'hFFFF_FFFD; ld_pre = 1; ld_frc = 1; step(1);
    ld_pre = 0; ld_frc = 0;
    chk("R6 pre load", pre_q, 16'hFFFD); chk("R6 frc load", frc_q, 32'hFFFF_FFFD);
    wr_data = 3; ld_pre = 1; step(1); ld_pre = 0;
    chk("R6 pre load2", pre_q, 3);

    // R5 hold while stopped
    step(5);
    chk("R5 pre hold", pre_q, 3); chk("R5 frc hold", frc_q, 32'hFFFF_FFFD);

    // R2/R3 with terminal 4
    cmp_val = 4; run = 1; step(1);
    chk("R2 step", pre_q, 4);
    step(1);
    chk("R3 wrap pre", pre_q, 0); chk("R3 frc adv", frc_q, 32'hFFFF_FFFE);
    step(20);

    // R4/R8 with terminal 0, across the 32-bit wrap
    run = 0; step(1);
    wr_data = 32'hFFFF_FFFF; ld_frc = 1; ld_pre = 1; step(1);
    wr_data = 0; ld_frc = 0; step(1); ld_pre = 0;
    cmp_val = 0; run = 1; step(1);
    chk("R8 wrap", frc_q, 0); chk("R4 pre zero", pre_q, 0);
    step(1);
    chk("R4 every clock", frc_q, 1);

    // R7 loads ignored while running
    wr_data = 32'h0000_1234; ld_frc = 1; ld_pre = 1; step(1);
    ld_frc = 0; ld_pre = 0;
    chk("R7 frc ignore", frc_q, 2); chk("R7 pre ignore", pre_q, 0);

    // R9 snapshot on selected source
    cmp_val = 7; src_sel = 2; step(3);
    snap_frc = frc_q; snap_pre = pre_q;
    evt_in[2] = 1; step(1); evt_in[2] = 0;
    chk("R9 snap frc", cap_frc_q, snap_frc); chk("R9 snap pre", cap_pre_q, snap_pre);

    // R10 held level gives one snapshot
    src_sel = 3; step(2);
    snap_pre = pre_q; evt_in[3] = 1; step(1);
    chk("R10 first", cap_pre_q, snap_pre);
    step(10);
    chk("R10 held once", cap_pre_q, snap_pre);
    evt_in[3] = 0;

    // R10 unselected source and out-of-range code
    evt_in[5] = 1; step(3); evt_in[5] = 0;
    chk("R10 unselected", cap_pre_q, snap_pre);
    src_sel = 6; step(2); evt_in[0] = 1; step(3); evt_in[0] = 0;
    chk("R10 code 6", cap_pre_q, snap_pre);

    // R9 snapshot while stopped
    run = 0; src_sel = 1; step(2);
    evt_in[1] = 1; step(1); evt_in[1] = 0;
    chk("R9 stopped snap", cap_frc_q, frc_q);
    step(4);
    finish_run();
  end
endmodule